// File: doc/BRIEF.md
# Serial Write-Only Display Byte Receiver

This block is the serial slave input of a display controller. A host drives a clock line, a data line, an active-low select and a command/data flag line. While select is low, the block shifts in one bit on each rising serial-clock edge, most significant bit first. After eight bits it hands the byte to the core as a single-cycle strobe. A flag next to the byte tells the core whether it goes to the pixel memory or to the command decoder.

All four host lines are asynchronous to the core clock. Each passes through a synchroniser chain, and serial-clock edges are found in the core clock domain. Nothing can be read back over the link. Raising select in the middle of a byte throws away the bits received so far. Select may also be held low for good, so the device stays selected and bytes follow one another.

Top module: `spi_wr_rx`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `rx_valid` is 0, `rx_byte` is 0x00 and `rx_is_data` is 0.
- R2: While `spi_cs_n` is low, `spi_sdin` is taken on each rising `spi_sclk` edge, and falling edges have no effect. The first bit taken becomes bit 7 of `rx_byte`, and eight bits make one byte.
- R3: When `spi_dc` is 1 at the eighth rising edge, the byte is delivered with `rx_is_data` = 1 (display data).
- R4: When `spi_dc` is 0 at the eighth rising edge, the byte is delivered with `rx_is_data` = 0 (command).
- R5: Only the level of `spi_dc` at the eighth rising edge counts. Its level during bits one to seven has no effect.
- R6: Rising `spi_sclk` edges while `spi_cs_n` is high produce no byte and leave `rx_byte` and `rx_is_data` unchanged.
- R7: `spi_cs_n` going high before the eighth bit discards the partial byte. The next byte after reselection is built only from bits received after reselection.
- R8: Each completed byte raises `rx_valid` for exactly one `clk` cycle.
- R9: With `spi_cs_n` held low, consecutive bytes are assembled one after another with no gap between them.
- R10: `rx_byte` and `rx_is_data` keep their values between `rx_valid` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| spi_sclk | input | 1 | Serial clock from host, asynchronous |
| spi_sdin | input | 1 | Serial data from host, asynchronous |
| spi_cs_n | input | 1 | Select, active low, asynchronous |
| spi_dc | input | 1 | Byte kind: 1 display data, 0 command |
| rx_valid | output | 1 | One-cycle strobe for a completed byte |
| rx_byte | output | 8 | Last completed byte |
| rx_is_data | output | 1 | Kind of the last completed byte |

## Verification
The checks assume the serial clock is much slower than the core clock. Each high and low phase of `spi_sclk` must span at least three core cycles so that every edge survives the synchroniser. The checks also assume `spi_sdin` and `spi_dc` stay steady across a rising edge, and `spi_cs_n` only changes while `spi_sclk` is low. The stimulus holds each serial phase for four core cycles and changes data, flag and select only in the low phase, on falling core-clock edges. Under these conditions, a byte strobe can follow only a synchronised rising edge taken while select was low, and the flag it carries is the synchronised flag level from the cycle before.

// File: rtl/spi_wr_pkg.sv
`timescale 1ns/1ps
package spi_wr_pkg;
   // Kind of a completed byte as presented to the core
   typedef enum logic {
      RX_KIND_CMD  = 1'b0,
      RX_KIND_DATA = 1'b1
   } rx_kind_e;

   // Bit positions inside the synchronised pin bundle
   localparam int PIN_DC   = 0;
   localparam int PIN_CS_N = 1;
   localparam int PIN_SDIN = 2;
   localparam int PIN_SCLK = 3;
   localparam int PIN_CNT  = 4;
endpackage

// File: rtl/spi_wr_sync.sv
`timescale 1ns/1ps
module spi_wr_sync #(
   parameter int             WIDTH  = 1,
   parameter int             STAGES = 2,
   parameter logic [WIDTH-1:0] INIT = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      initial $fatal(1, "spi_wr_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      initial $fatal(1, "spi_wr_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) stg[i] <= INIT;
            else     stg[i] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) stg[i] <= INIT;
            else     stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_wr_edge.sv
`timescale 1ns/1ps
module spi_wr_edge #(
   parameter bit RISING = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic lvl,
   output logic pulse
);
   logic prev;

   always_ff @(posedge clk) begin
      if (rst) prev <= 1'b0;
      else     prev <= lvl;
   end

   if (RISING) begin : g_rise
      assign pulse = lvl & ~prev;
   end else begin : g_fall
      assign pulse = ~lvl & prev;
   end
endmodule

// File: rtl/spi_wr_assemble.sv
`timescale 1ns/1ps
module spi_wr_assemble #(
   parameter int DATA_W    = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sel,
   input  logic              shift_en,
   input  logic              bit_in,
   input  logic              kind_in,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_byte,
   output logic              out_kind
);
   localparam int          CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

   if (DATA_W < 2) begin : g_bad_width
      initial $fatal(1, "spi_wr_assemble: DATA_W must be at least 2");
   end

   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] shreg;
   logic [DATA_W-1:0] shnext;

   if (MSB_FIRST) begin : g_msb
      assign shnext = {shreg[DATA_W-2:0], bit_in};
   end else begin : g_lsb
      assign shnext = {bit_in, shreg[DATA_W-1:1]};
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt       <= '0;
         shreg     <= '0;
         out_valid <= 1'b0;
         out_byte  <= '0;
         out_kind  <= 1'b0;
      end else begin
         out_valid <= 1'b0;
         if (!sel) begin
            cnt   <= '0;
            shreg <= '0;
         end else if (shift_en) begin
            if (cnt == LAST) begin
               cnt       <= '0;
               shreg     <= '0;
               out_valid <= 1'b1;
               out_byte  <= shnext;
               out_kind  <= kind_in;
            end else begin
               cnt   <= cnt + 1'b1;
               shreg <= shnext;
            end
         end
      end
   end
endmodule

// File: rtl/spi_wr_rx.sv
`timescale 1ns/1ps
module spi_wr_rx #(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit MSB_FIRST   = 1'b1,
   parameter bit SAMPLE_RISE = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              spi_sclk,
   input  logic              spi_sdin,
   input  logic              spi_cs_n,
   input  logic              spi_dc,
   output logic              rx_valid,
   output logic [DATA_W-1:0] rx_byte,
   output logic              rx_is_data
);
   import spi_wr_pkg::*;

   localparam logic [PIN_CNT-1:0] PIN_INIT = PIN_CNT'(1) << PIN_CS_N;

   logic [PIN_CNT-1:0] pins_raw;
   logic [PIN_CNT-1:0] pins_s;
   logic               sclk_s;
   logic               sdin_s;
   logic               cs_n_s;
   logic               dc_s;
   logic               sclk_rise;
   rx_kind_e           kind_in;
   logic               kind_out;

   always_comb begin
      pins_raw           = '0;
      pins_raw[PIN_SCLK] = spi_sclk;
      pins_raw[PIN_SDIN] = spi_sdin;
      pins_raw[PIN_CS_N] = spi_cs_n;
      pins_raw[PIN_DC]   = spi_dc;
   end

   spi_wr_sync #(
      .WIDTH (PIN_CNT),
      .STAGES(SYNC_STAGES),
      .INIT  (PIN_INIT)
   ) u_sync (
      .clk(clk),
      .rst(rst),
      .d  (pins_raw),
      .q  (pins_s)
   );

   assign sclk_s  = pins_s[PIN_SCLK];
   assign sdin_s  = pins_s[PIN_SDIN];
   assign cs_n_s  = pins_s[PIN_CS_N];
   assign dc_s    = pins_s[PIN_DC];
   assign kind_in = dc_s ? RX_KIND_DATA : RX_KIND_CMD;

   spi_wr_edge #(
      .RISING(SAMPLE_RISE)
   ) u_edge (
      .clk  (clk),
      .rst  (rst),
      .lvl  (sclk_s),
      .pulse(sclk_rise)
   );

   spi_wr_assemble #(
      .DATA_W   (DATA_W),
      .MSB_FIRST(MSB_FIRST)
   ) u_asm (
      .clk      (clk),
      .rst      (rst),
      .sel      (~cs_n_s),
      .shift_en (sclk_rise),
      .bit_in   (sdin_s),
      .kind_in  (kind_in),
      .out_valid(rx_valid),
      .out_byte (rx_byte),
      .out_kind (kind_out)
   );

   assign rx_is_data = kind_out;
endmodule

// File: rtl/spi_wr_rx_chk.sv
`timescale 1ns/1ps
module spi_wr_rx_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              rx_valid,
   input logic [DATA_W-1:0] rx_byte,
   input logic              rx_is_data,
   input logic              sclk_rise,
   input logic              cs_n_s,
   input logic              dc_s
);
   p_reset_clear_r1: assert property (@(posedge clk)
      rst |=> (!rx_valid && rx_byte == '0 && !rx_is_data));

   p_strobe_after_edge_r2: assert property (@(posedge clk) disable iff (rst)
      rx_valid |-> $past(sclk_rise));

   p_kind_follows_dc_r3: assert property (@(posedge clk) disable iff (rst)
      rx_valid |-> (rx_is_data == $past(dc_s)));

   p_deselect_quiet_r6: assert property (@(posedge clk) disable iff (rst)
      $past(cs_n_s) |-> !rx_valid);

   p_single_pulse_r8: assert property (@(posedge clk) disable iff (rst)
      rx_valid |=> !rx_valid);

   p_hold_outputs_r10: assert property (@(posedge clk) disable iff (rst)
      !rx_valid |-> ($stable(rx_byte) && $stable(rx_is_data)));
endmodule

bind spi_wr_rx spi_wr_rx_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .rx_valid  (rx_valid),
   .rx_byte   (rx_byte),
   .rx_is_data(rx_is_data),
   .sclk_rise (sclk_rise),
   .cs_n_s    (cs_n_s),
   .dc_s      (dc_s)
);

// File: tb/spi_wr_rx_tb.sv
`timescale 1ns/1ps
module spi_wr_rx_tb;
   localparam int HALF = 4;   // core cycles per serial phase

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       sclk = 1'b0;
   logic       sdin = 1'b0;
   logic       cs_n = 1'b1;
   logic       dc = 1'b0;
   logic       rx_valid;
   logic [7:0] rx_byte;
   logic       rx_is_data;

   int checks = 0;
   int errors = 0;
   int pulses = 0;
   int wide   = 0;
   logic       prev_valid = 1'b0;
   logic [7:0] cap_byte = 8'h00;
   logic       cap_data = 1'b0;

   always #4 clk = ~clk;

   spi_wr_rx u_dut (
      .clk(clk), .rst(rst),
      .spi_sclk(sclk), .spi_sdin(sdin), .spi_cs_n(cs_n), .spi_dc(dc),
      .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_is_data(rx_is_data)
   );

   always @(negedge clk) begin
      if (rx_valid) begin
         pulses   <= pulses + 1;
         cap_byte <= rx_byte;
         cap_data <= rx_is_data;
         if (prev_valid) wide <= wide + 1;
      end
      prev_valid <= rx_valid;
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // one serial bit; dc level applied for this bit
   task automatic send_bit(input logic b, input logic d);
      @(negedge clk);
      sdin = b;
      dc   = d;
      idle(HALF);
      sclk = 1'b1;
      idle(HALF);
      sclk = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] b, input logic dc_early, input logic dc_last);
      for (int i = 7; i >= 0; i--) send_bit(b[i], (i == 0) ? dc_last : dc_early);
      idle(HALF);
   endtask

   task automatic t_reset();
      idle(2);
      check("R1 valid", rx_valid, 0);
      check("R1 byte", rx_byte, 0);
      check("R1 kind", rx_is_data, 0);
   endtask

   task automatic t_data_byte(input logic [7:0] b);
      int p0 = pulses;
      send_byte(b, 1'b1, 1'b1);
      check("R2 one byte per 8 bits", pulses - p0, 1);
      check("R2 msb first value", cap_byte, b);
      check("R3 data kind", cap_data, 1);
   endtask

   task automatic t_cmd_byte(input logic [7:0] b);
      int p0 = pulses;
      send_byte(b, 1'b0, 1'b0);
      check("R4 pulse", pulses - p0, 1);
      check("R4 value", cap_byte, b);
      check("R4 command kind", cap_data, 0);
   endtask

   task automatic t_dc_late();
      send_byte(8'h5A, 1'b1, 1'b0);
      check("R5 early high last low", cap_data, 0);
      send_byte(8'hC3, 1'b0, 1'b1);
      check("R5 early low last high", cap_data, 1);
      check("R5 value", cap_byte, 8'hC3);
   endtask

   task automatic t_cs_ignore();
      int p0;
      logic [7:0] hold_b;
      logic       hold_d;
      idle(2);
      hold_b = rx_byte;
      hold_d = rx_is_data;
      cs_n = 1'b1;
      idle(HALF);
      p0 = pulses;
      send_byte(8'h0F, 1'b0, 1'b0);
      send_byte(8'hF0, 1'b0, 1'b0);
      check("R6 no pulse deselected", pulses - p0, 0);
      check("R6 R10 byte held", rx_byte, hold_b);
      check("R6 R10 kind held", rx_is_data, hold_d);
      cs_n = 1'b0;
      idle(HALF);
   endtask

   task automatic t_abort();
      int p0 = pulses;
      send_bit(1'b1, 1'b1);
      send_bit(1'b1, 1'b1);
      send_bit(1'b1, 1'b1);
      idle(2);
      cs_n = 1'b1;
      idle(HALF * 2);
      cs_n = 1'b0;
      idle(HALF);
      send_byte(8'h81, 1'b0, 1'b1);
      check("R7 single byte after abort", pulses - p0, 1);
      check("R7 fresh byte", cap_byte, 8'h81);
   endtask

   task automatic t_back_to_back();
      logic [7:0] seq [3] = '{8'h12, 8'h34, 8'h56};
      int p0 = pulses;
      for (int k = 0; k < 3; k++) begin
         for (int i = 7; i >= 0; i--) send_bit(seq[k][i], k[0]);
         idle(HALF);
         check("R9 stream value", cap_byte, seq[k]);
         check("R9 stream kind", cap_data, k[0]);
      end
      check("R9 stream count", pulses - p0, 3);
   endtask

   initial begin
      idle(5);
      t_reset();
      rst = 1'b0;
      idle(4);
      cs_n = 1'b0;
      idle(HALF);
      t_data_byte(8'hA5);
      t_data_byte(8'h00);
      t_data_byte(8'hFF);
      t_cmd_byte(8'h3C);
      t_dc_late();
      t_cs_ignore();
      t_abort();
      t_back_to_back();
      idle(4);
      check("R8 one-cycle strobe", wide, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule